// File: doc/BRIEF.md
# Time Snapshot Register File with Change Flags

This block is a small byte-addressed register file placed between a host access engine and a live time-of-day counter. The host never reads the counter itself. Instead it issues a capture command that freezes every live field (seconds through week number) into a bank of snapshot bytes. The same command records, per field, whether the value moved since the previous capture. Software polls the flag byte and re-reads only the fields that changed.

Setting the time works the other way round. The host writes the wanted fields into the snapshot bytes, then issues a load command. The block presents the snapshot to the counter with a one-cycle load strobe and clears all change flags. A lock bit in the control byte blocks the load command, so that a stray command cannot overwrite the clock.

The control byte also carries two test-mode bits, which go straight to the counter, and a frequency-measurement enable. While that enable is set and the chip is deselected, the data pin driver produces a 256 Hz square wave. Its half period is derived from the block's clock rate.

Top module: `snap_regfile`

## Requirements
- R1: After reset the control byte, the flag byte and all eight snapshot bytes read 0x00, `load_o` is low and `freq_o` is low.
- R2: A write to address 0 stores bits 0 (frequency enable), 2 and 3 (test modes) and 4 (time-set lock). Bits 1, 5, 6 and 7 always read 0. `test_mode_o` equals {bit 3, bit 2} of the stored byte.
- R3: Addresses 2..9 are host read/write bytes holding seconds, minutes, hours, day of month, month, year, weekday and week number, in that order. Field k (address k+2) occupies bits [8k+7:8k] of `live_i` and `load_fields_o`.
- R4: Address 1 reads the flag byte, and host writes to it are ignored. Addresses 0xA..0xF read 0x00, and writes to them change no register.
- R5: A command with `cmd_i` = 0xF copies every live field into its snapshot byte at the next clock edge. It sets flag bit k to 1 exactly when live field k differs from the previous snapshot byte k.
- R6: A command with `cmd_i` = 0xE while the lock bit is clear drives `load_o` high in that same cycle, with `load_fields_o` equal to the snapshot bytes. The flag byte is 0x00 after the next edge and the snapshot is left unchanged.
- R7: A command with `cmd_i` = 0xE while the lock bit is set keeps `load_o` low and leaves the flags unchanged.
- R8: Without a host write or a 0xF command, the snapshot bytes hold their values while the live fields change. Command codes other than 0xE and 0xF have no effect.
- R9: When a 0xF command and a host write to a snapshot address occur in the same cycle, the live value is stored.
- R10: While control bit 0 is set and `cs_ni` is high, `freq_o` is high for HALF = CLK_HZ/512 cycles and then low for HALF cycles, repeating, starting high in the first such cycle. Otherwise `freq_o` is low, and the pattern restarts when the condition returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Host register address |
| we_i | input | 1 | Host write strobe |
| wdata_i | input | FIELD_W | Host write data |
| rdata_o | output | FIELD_W | Read data for `addr_i` |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | ADDR_W | Command code |
| live_i | input | NUM_FIELDS*FIELD_W | Live counter fields |
| load_o | output | 1 | Counter load strobe |
| load_fields_o | output | NUM_FIELDS*FIELD_W | Values to load into the counter |
| test_mode_o | output | 2 | Test-mode bits to the counter |
| cs_ni | input | 1 | Chip select, active low |
| freq_o | output | 1 | Frequency-measurement drive for the data pin |

## Verification
The bench builds the block with CLK_HZ = 2048, which makes HALF four cycles. The whole on/off pattern, its restart after a deselect and several full periods therefore fit within a few dozen cycles. Field count and width stay at their defaults of eight bytes. This puts every snapshot address, the flag bit positions and the unmapped addresses 0xA..0xF within reach of the directed sequence and of the per-cycle reference model.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int NUM_FIELDS_D = 8;
  localparam int FIELD_W_D    = 8;
  localparam int ADDR_W_D     = 4;

  localparam logic [3:0] CMD_TO_CLOCK = 4'hE;
  localparam logic [3:0] CMD_TO_REGS  = 4'hF;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_FLAGS  = 1;
  localparam int FIELD_BASE  = 2;

  localparam int CTRL_FREQ = 0;
  localparam int CTRL_TM0  = 2;
  localparam int CTRL_TM1  = 3;
  localparam int CTRL_LOCK = 4;
  localparam logic [7:0] CTRL_MASK = 8'h1D;
endpackage

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg
  import snap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctrl_o,
  output logic       lock_o,
  output logic       freq_en_o,
  output logic [1:0] test_mode_o
);
  logic [7:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & CTRL_MASK;
  end

  assign ctrl_o      = ctrl_q;
  assign lock_o      = ctrl_q[CTRL_LOCK];
  assign freq_en_o   = ctrl_q[CTRL_FREQ];
  assign test_mode_o = {ctrl_q[CTRL_TM1], ctrl_q[CTRL_TM0]};

  // R2: a write lands on the following edge, reserved bits dropped
  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((ctrl_o | CTRL_MASK) == CTRL_MASK) && (lock_o == $past(wdata_i[CTRL_LOCK])));
endmodule

// File: rtl/snap_field_bank.sv
module snap_field_bank #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 8,
  localparam int BUS_W     = NUM_FIELDS * FIELD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FIELDS-1:0] wr_en_i,
  input  logic [FIELD_W-1:0]    wdata_i,
  input  logic                  copy_i,
  input  logic                  clear_flags_i,
  input  logic [BUS_W-1:0]      live_i,
  output logic [BUS_W-1:0]      snap_o,
  output logic [NUM_FIELDS-1:0] flags_o
);
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    logic [FIELD_W-1:0] snap_q;
    logic               flag_q;
    logic [FIELD_W-1:0] live_k;

    assign live_k = live_i[k*FIELD_W +: FIELD_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        snap_q <= '0;
        flag_q <= 1'b0;
      end else if (copy_i) begin
        snap_q <= live_k;
        flag_q <= (live_k != snap_q);
      end else begin
        if (wr_en_i[k])    snap_q <= wdata_i;
        if (clear_flags_i) flag_q <= 1'b0;
      end
    end

    assign snap_o[k*FIELD_W +: FIELD_W] = snap_q;
    assign flags_o[k] = flag_q;
  end

  // R5: capture takes the live value seen at the command edge
  a_r5_copy_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_i |=> snap_o == $past(live_i));
  // R6: load command leaves no flag standing
  a_r6_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_flags_i && !copy_i) |=> flags_o == '0);
  // R8: snapshot frozen without writes or capture
  a_r8_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!copy_i && wr_en_i == '0) |=> $stable(snap_o));
endmodule

// File: rtl/snap_freq_div.sv
module snap_freq_div #(
  parameter int HALF_CYCLES = 64,
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic pulse_o
);
  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == CW'(HALF_CYCLES - 1)) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = en_i & phase_q;

  // R10: no level change in the middle of a half period
  a_r10_half_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && ($past(cnt_q) != CW'(HALF_CYCLES - 1))) |-> $stable(pulse_o));
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HALF_CYCLES - 1));
endmodule

// File: rtl/snap_regfile.sv
module snap_regfile
  import snap_pkg::*;
#(
  parameter int NUM_FIELDS = NUM_FIELDS_D,
  parameter int FIELD_W    = FIELD_W_D,
  parameter int ADDR_W     = ADDR_W_D,
  parameter int CLK_HZ     = 32768,
  localparam int BUS_W     = NUM_FIELDS * FIELD_W,
  localparam int HALF      = CLK_HZ / 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] rdata_o,
  input  logic               cmd_valid_i,
  input  logic [ADDR_W-1:0]  cmd_i,
  input  logic [BUS_W-1:0]   live_i,
  output logic               load_o,
  output logic [BUS_W-1:0]   load_fields_o,
  output logic [1:0]         test_mode_o,
  input  logic               cs_ni,
  output logic               freq_o
);
  logic [7:0]            ctrl;
  logic                  lock;
  logic                  freq_en;
  logic                  ctrl_we;
  logic                  cmd_copy;
  logic                  cmd_load;
  logic [NUM_FIELDS-1:0] wr_field;
  logic [NUM_FIELDS-1:0] flags;
  logic [BUS_W-1:0]      snap;

  assign ctrl_we  = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign cmd_copy = cmd_valid_i && (cmd_i == ADDR_W'(CMD_TO_REGS));
  assign cmd_load = cmd_valid_i && (cmd_i == ADDR_W'(CMD_TO_CLOCK)) && !lock;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_dec
    assign wr_field[k] = we_i && (addr_i == ADDR_W'(FIELD_BASE + k));
  end

  snap_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we),
    .wdata_i     (wdata_i[7:0]),
    .ctrl_o      (ctrl),
    .lock_o      (lock),
    .freq_en_o   (freq_en),
    .test_mode_o (test_mode_o)
  );

  snap_field_bank #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W)
  ) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_field),
    .wdata_i       (wdata_i),
    .copy_i        (cmd_copy),
    .clear_flags_i (cmd_load),
    .live_i        (live_i),
    .snap_o        (snap),
    .flags_o       (flags)
  );

  snap_freq_div #(
    .HALF_CYCLES (HALF)
  ) u_freq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (freq_en && cs_ni),
    .pulse_o (freq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))  rdata_o = FIELD_W'(ctrl);
    if (addr_i == ADDR_W'(ADDR_FLAGS)) rdata_o = FIELD_W'(flags);
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (addr_i == ADDR_W'(FIELD_BASE + k)) rdata_o = snap[k*FIELD_W +: FIELD_W];
    end
  end

  assign load_o        = cmd_load;
  assign load_fields_o = snap;

  // R4: host writes never reach the flag byte
  a_r4_flags_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(ADDR_FLAGS) && !cmd_valid_i) |=> $stable(flags));
  // R7: locked load command leaves flags alone
  a_r7_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == ADDR_W'(CMD_TO_CLOCK) && lock) |=> $stable(flags));
endmodule

// File: tb/snap_regfile_tb.sv
module snap_regfile_tb;
  localparam int CLK_HZ = 2048;
  localparam int HALF   = CLK_HZ / 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic [7:0]  live [8];
  logic [63:0] live_flat;
  logic        load;
  logic [63:0] load_fields;
  logic [1:0]  test_mode;
  logic        cs_n = 1'b1;
  logic        freq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  always_comb for (int k = 0; k < 8; k++) live_flat[k*8 +: 8] = live[k];

  snap_regfile #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .live_i(live_flat),
    .load_o(load), .load_fields_o(load_fields), .test_mode_o(test_mode),
    .cs_ni(cs_n), .freq_o(freq)
  );

  // reference model
  logic [7:0] m_ctrl, m_flags;
  logic [7:0] m_snap [8];
  int         m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl  <= 8'h00;
      m_flags <= 8'h00;
      for (int k = 0; k < 8; k++) m_snap[k] <= 8'h00;
      m_act <= 0;
    end else begin
      if (we && addr == 4'h0) m_ctrl <= wdata & 8'h1D;
      if (cmd_valid && cmd == 4'hF) begin
        for (int k = 0; k < 8; k++) begin
          m_snap[k]  <= live[k];
          m_flags[k] <= (live[k] != m_snap[k]);
        end
      end else begin
        for (int k = 0; k < 8; k++) if (we && addr == 4'(k + 2)) m_snap[k] <= wdata;
        if (cmd_valid && cmd == 4'hE && !m_ctrl[4]) m_flags <= 8'h00;
      end
      m_act <= (m_ctrl[0] && cs_n) ? m_act + 1 : 0;
    end
  end

  function automatic logic [7:0] m_read(logic [3:0] a);
    if (a == 4'h0) return m_ctrl;
    if (a == 4'h1) return m_flags;
    if (a >= 4'h2 && a <= 4'h9) return m_snap[a - 4'h2];
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  logic m_load;
  logic m_freq;
  logic [63:0] m_flat;
  always_comb begin
    m_load = cmd_valid && cmd == 4'hE && !m_ctrl[4];
    m_freq = m_ctrl[0] && cs_n && (((m_act / HALF) % 2) == 0);
    for (int k = 0; k < 8; k++) m_flat[k*8 +: 8] = m_snap[k];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk((addr == 4'h0) ? "R2" : (addr == 4'h1) ? "R4" : (addr <= 4'h9) ? "R3" : "R4",
          64'(rdata), 64'(m_read(addr)));
      chk("R6", 64'(load), 64'(m_load));
      if (m_load) chk("R6", load_fields, m_flat);
      chk("R2", 64'(test_mode), 64'({m_ctrl[3], m_ctrl[2]}));
      chk("R10", 64'(freq), 64'(m_freq));
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; we = 1'b1; wdata = d; step(); we = 1'b0;
  endtask
  task automatic issue(logic [3:0] c);
    cmd_valid = 1'b1; cmd = c; step(); cmd_valid = 1'b0;
  endtask
  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    addr = a; @(negedge clk); chk(tag, 64'(rdata), 64'(exp)); step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout exp done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) live[k] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(load), 64'(0));
    chk("R1", 64'(freq), 64'(0));
    step();
    rd(4'h0, 8'h00, "R1");
    rd(4'h1, 8'h00, "R1");
    rd(4'h2, 8'h00, "R1");
    rd(4'h9, 8'h00, "R1");

    wr(4'h0, 8'hFE);
    rd(4'h0, 8'h1C, "R2");
    chk("R2", 64'(test_mode), 64'(3));
    wr(4'h0, 8'h04);
    chk("R2", 64'(test_mode), 64'(1));
    wr(4'h0, 8'h00);

    for (int i = 0; i < 8; i++) wr(4'(i + 2), 8'(8'h10 + i));
    for (int i = 0; i < 8; i++) rd(4'(i + 2), 8'(8'h10 + i), "R3");

    wr(4'h1, 8'hAA);
    for (int a = 10; a < 16; a++) wr(4'(a), 8'h55);
    rd(4'h1, 8'h00, "R4");
    for (int a = 10; a < 16; a++) rd(4'(a), 8'h00, "R4");
    rd(4'h0, 8'h00, "R4");
    rd(4'h2, 8'h10, "R4");

    for (int k = 0; k < 8; k++) live[k] = 8'(8'h10 + k);
    live[0] = 8'h59;
    live[3] = 8'h31;
    issue(4'hF);
    rd(4'h1, 8'h09, "R5");
    rd(4'h2, 8'h59, "R5");
    rd(4'h5, 8'h31, "R5");
    rd(4'h3, 8'h11, "R5");
    live[1] = 8'h22;
    issue(4'hF);
    rd(4'h1, 8'h02, "R5");

    live[2] = 8'h99;
    repeat (5) step();
    issue(4'h3);
    rd(4'h4, 8'h12, "R8");
    rd(4'h1, 8'h02, "R8");

    wr(4'h0, 8'h10);
    cmd_valid = 1'b1; cmd = 4'hE;
    @(negedge clk); chk("R7", 64'(load), 64'(0));
    step(); cmd_valid = 1'b0;
    rd(4'h1, 8'h02, "R7");

    wr(4'h0, 8'h00);
    cmd_valid = 1'b1; cmd = 4'hE;
    @(negedge clk);
    chk("R6", 64'(load), 64'(1));
    chk("R6", load_fields, 64'h1716_1514_3112_2259);
    step(); cmd_valid = 1'b0;
    rd(4'h1, 8'h00, "R6");
    rd(4'h2, 8'h59, "R6");

    live[0] = 8'h42;
    addr = 4'h2; we = 1'b1; wdata = 8'h77; cmd_valid = 1'b1; cmd = 4'hF;
    step(); we = 1'b0; cmd_valid = 1'b0;
    rd(4'h2, 8'h42, "R9");

    wr(4'h0, 8'h01);
    @(negedge clk); chk("R10", 64'(freq), 64'(1));
    repeat (HALF) @(posedge clk);
    @(negedge clk); chk("R10", 64'(freq), 64'(0));
    repeat (3 * HALF) step();
    cs_n = 1'b0;
    @(negedge clk); chk("R10", 64'(freq), 64'(0));
    step(); step();
    cs_n = 1'b1;
    @(negedge clk); chk("R10", 64'(freq), 64'(1));
    repeat (4 * HALF + 1) step();
    wr(4'h0, 8'h00);
    @(negedge clk); chk("R10", 64'(freq), 64'(0));
    step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule